// File: doc/BRIEF.md
# x86 ModRM/SIB Operand Length Resolver

This block sits behind an x86 opcode recogniser. Once the opcode and its opcode map are known, it works out the effective operand size and the effective address size. It then walks the bytes that belong to the operands: the ModRM byte, an optional SIB byte, the displacement and the immediate. It takes one byte per valid/ready handshake, in that fixed order, and skips every field the instruction does not have. When the last present field has been taken, it raises a one-cycle `done`. At that moment it presents the ModRM and SIB bytes, the sign-extended displacement and immediate, and their byte counts.

A small writable table, indexed by opcode map and opcode, tells the block whether a ModRM byte follows and which immediate size class applies. The table is a block-RAM-style memory with one registered read port. After `start`, the block therefore spends one lookup cycle before it asks for bytes. What the instruction means is decided elsewhere.

Top module: `xlen_operand_walker`

## Requirements
- R1: The effective operand size (`op_size`, in bytes) is 8 when `rex_w` is 1. Otherwise it is 2^`alt_op_log` when `pfx_opsz` is 1, and 2^`def_op_log` when neither applies. The log codes are 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R2: The effective address size (`addr_size`) is 2^`alt_ad_log` when `pfx_adsz` is 1, and 2^`def_ad_log` otherwise.
- R3: Table entries are written with `cfg_we` at the address {`cfg_map`, `cfg_opc`}. The map codes are 0 = one-byte, 1 = 0F, 2 = 0F38 and 3 = 0F3A. An entry marked `cfg_modrm` expects a ModRM byte. The immediate size classes are 0 = none, 1 = one byte, 2 = two bytes, 3 = operand size capped at 4, and 4 = operand size. For one-byte-map opcodes A0 to A3, the class is scaled by the address size instead of the operand size.
- R4: With 2-byte addressing, the displacement is 2 bytes when mod=0 and rm=6, or when mod=2. It is 1 byte when mod=1 and none otherwise. No SIB byte is ever taken in this mode.
- R5: With 4- or 8-byte addressing, the displacement is 4 bytes when mod=0 and rm=5, or when mod=2. It is 1 byte when mod=1 and none otherwise.
- R6: A SIB byte is taken only when rm=4, mod is not 3 and the addressing is not 2-byte. If such a SIB has base field bits [2:0] = 5 and mod=0, the displacement becomes 4 bytes.
- R7: For one-byte-map opcodes F6 and F7 whose ModRM reg field is 0 or 1, an immediate is added. It is 1 byte for F6. For F7 it is the operand size capped at 4 bytes.
- R8: Bytes are taken in the order ModRM, SIB, displacement, immediate, and absent fields are skipped. `in_ready` is high only while a byte is expected. `done` pulses for one cycle on the cycle after the last byte is taken, or two cycles after `start` when no bytes follow.
- R9: Displacement bytes are assembled little-endian and sign-extended to 64 bits from 1, 2 or 4 bytes. `disp_size` gives the count, and 0 with `disp` = 0 means no displacement.
- R10: Immediate bytes are assembled little-endian. A 1-byte or 4-byte immediate is sign-extended to 64 bits, while 2-byte and 8-byte immediates are zero-extended unchanged. `imm_size` gives the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write enable |
| cfg_map | input | 2 | Table write opcode map |
| cfg_opc | input | 8 | Table write opcode |
| cfg_modrm | input | 1 | Entry expects a ModRM byte |
| cfg_imm_ty | input | 3 | Entry immediate size class |
| start | input | 1 | Begin resolving (taken when idle) |
| op_map | input | 2 | Opcode map of the instruction |
| opcode | input | 8 | Final opcode byte |
| rex_w | input | 1 | 64-bit operand flag |
| pfx_opsz | input | 1 | Operand-size override present |
| pfx_adsz | input | 1 | Address-size override present |
| def_op_log | input | 2 | Default operand size, log2 bytes |
| alt_op_log | input | 2 | Alternate operand size, log2 bytes |
| def_ad_log | input | 2 | Default address size, log2 bytes |
| alt_ad_log | input | 2 | Alternate address size, log2 bytes |
| in_valid | input | 1 | Stream byte valid |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | A byte is expected |
| done | output | 1 | Fields complete, one-cycle pulse |
| op_size | output | 4 | Effective operand size in bytes |
| addr_size | output | 4 | Effective address size in bytes |
| modrm | output | 8 | ModRM byte, 0 if absent |
| sib | output | 8 | SIB byte, 0 if absent |
| disp | output | 64 | Sign-extended displacement |
| disp_size | output | 3 | Displacement byte count |
| imm | output | 64 | Extended immediate |
| imm_size | output | 4 | Immediate byte count |

## Verification
The assertions take for granted that the four size log inputs hold only the codes 1 to 3, that `start` comes only while the block is idle, and that the table entry for the opcode was written beforehand. With those inputs, the operand and address sizes always come out as 2, 4 or 8, and the displacement and immediate widths always match their sign-extension rules.

The stimulus keeps within these assumptions. It writes every table entry it uses before the first instruction. It uses only legal log codes. It waits for each `done` before it issues the next `start`, and it offers a byte only while `in_ready` is high.

// File: rtl/xlw_pkg.sv
package xlw_pkg;
  localparam int VAL_W = 64;

  localparam logic [2:0] SZ_NONE = 3'd0;
  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;
  localparam logic [2:0] SZ_OPZ  = 3'd3;
  localparam logic [2:0] SZ_OPV  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } walk_st_e;

  // byte count of an immediate class at a given log2 size
  function automatic logic [3:0] class_bytes(logic [2:0] ty, logic [1:0] lg);
    logic [3:0] full;
    full = 4'd1 << lg;
    case (ty)
      SZ_BYTE: class_bytes = 4'd1;
      SZ_WORD: class_bytes = 4'd2;
      SZ_OPZ:  class_bytes = (full > 4'd4) ? 4'd4 : full;
      SZ_OPV:  class_bytes = full;
      default: class_bytes = 4'd0;
    endcase
  endfunction

  // widen an assembled field; ext16 selects sign extension at 2 bytes
  function automatic logic [VAL_W-1:0] widen(logic [VAL_W-1:0] v,
                                             logic [3:0] n, logic ext16);
    case (n)
      4'd1: widen = {{(VAL_W-8){v[7]}}, v[7:0]};
      4'd2: widen = ext16 ? {{(VAL_W-16){v[15]}}, v[15:0]}
                          : {{(VAL_W-16){1'b0}}, v[15:0]};
      4'd4: widen = {{(VAL_W-32){v[31]}}, v[31:0]};
      default: widen = v;
    endcase
  endfunction
endpackage

// File: rtl/xlw_type_ram.sv
module xlw_type_ram #(
  parameter int AW = 10,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xlw_size_sel.sv
module xlw_size_sel #(
  parameter int MAP_W = 2,
  parameter int OPC_W = 8
) (
  input  logic [MAP_W-1:0] map,
  input  logic [OPC_W-1:0] opc,
  input  logic             rex_w,
  input  logic             p66,
  input  logic             p67,
  input  logic [1:0]       def_op_log,
  input  logic [1:0]       alt_op_log,
  input  logic [1:0]       def_ad_log,
  input  logic [1:0]       alt_ad_log,
  input  logic [2:0]       imm_ty,
  output logic [1:0]       op_log,
  output logic [1:0]       ad_log,
  output logic [3:0]       imm_n
);
  import xlw_pkg::*;
  logic moffs;

  always_comb begin
    op_log = rex_w ? 2'd3 : (p66 ? alt_op_log : def_op_log);
    ad_log = p67 ? alt_ad_log : def_ad_log;
    moffs  = (map == '0) && (opc[OPC_W-1:2] == 6'b101000);
    imm_n  = class_bytes(imm_ty, moffs ? ad_log : op_log);
  end
endmodule

// File: rtl/xlw_modrm_dec.sv
module xlw_modrm_dec #(
  parameter int MAP_W = 2,
  parameter int OPC_W = 8
) (
  input  logic [7:0]       mrm,
  input  logic             ad16,
  input  logic [MAP_W-1:0] map,
  input  logic [OPC_W-1:0] opc,
  input  logic [3:0]       op_bytes,
  input  logic [3:0]       imm_in,
  output logic [2:0]       disp_n,
  output logic             want_sib,
  output logic [3:0]       imm_out
);
  logic [1:0] md;
  logic [2:0] rg, rm;

  always_comb begin
    md = mrm[7:6];
    rg = mrm[5:3];
    rm = mrm[2:0];
    if (ad16)
      disp_n = ((md == 2'd0 && rm == 3'd6) || md == 2'd2) ? 3'd2 :
               (md == 2'd1) ? 3'd1 : 3'd0;
    else
      disp_n = ((md == 2'd0 && rm == 3'd5) || md == 2'd2) ? 3'd4 :
               (md == 2'd1) ? 3'd1 : 3'd0;
    want_sib = (rm == 3'd4) && (md != 2'd3) && !ad16;
    imm_out  = imm_in;
    if (map == '0 && rg[2:1] == 2'b00) begin
      if (opc == 8'hF6) imm_out = 4'd1;
      else if (opc == 8'hF7) imm_out = (op_bytes > 4'd4) ? 4'd4 : op_bytes;
    end
  end
endmodule

// File: rtl/xlen_operand_walker.sv
module xlen_operand_walker #(
  parameter int MAP_W = 2,
  parameter int OPC_W = 8,
  parameter int TY_W  = 3,
  parameter int VAL_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [MAP_W-1:0] cfg_map,
  input  logic [OPC_W-1:0] cfg_opc,
  input  logic             cfg_modrm,
  input  logic [TY_W-1:0]  cfg_imm_ty,
  input  logic             start,
  input  logic [MAP_W-1:0] op_map,
  input  logic [OPC_W-1:0] opcode,
  input  logic             rex_w,
  input  logic             pfx_opsz,
  input  logic             pfx_adsz,
  input  logic [1:0]       def_op_log,
  input  logic [1:0]       alt_op_log,
  input  logic [1:0]       def_ad_log,
  input  logic [1:0]       alt_ad_log,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             done,
  output logic [3:0]       op_size,
  output logic [3:0]       addr_size,
  output logic [7:0]       modrm,
  output logic [7:0]       sib,
  output logic [VAL_W-1:0] disp,
  output logic [2:0]       disp_size,
  output logic [VAL_W-1:0] imm,
  output logic [3:0]       imm_size
);
  import xlw_pkg::*;
  localparam int AW = MAP_W + OPC_W;
  localparam int DW = TY_W + 1;

  walk_st_e         st;
  logic [DW-1:0]    ent;
  logic [MAP_W-1:0] map_q;
  logic [OPC_W-1:0] opc_q;
  logic             rexw_q, p66_q, p67_q;
  logic [1:0]       dop_q, aop_q, dad_q, aad_q;
  logic [3:0]       cnt;
  logic [1:0]       op_log, ad_log;
  logic [3:0]       look_imm;
  logic [2:0]       dec_disp;
  logic             dec_sib;
  logic [3:0]       dec_imm;
  logic [VAL_W-1:0] disp_acc, imm_acc;
  logic             take;

  xlw_type_ram #(.AW(AW), .DW(DW)) u_tbl (
    .clk(clk), .we(cfg_we), .waddr({cfg_map, cfg_opc}),
    .wdata({cfg_modrm, cfg_imm_ty}), .raddr({op_map, opcode}), .rdata(ent)
  );

  xlw_size_sel #(.MAP_W(MAP_W), .OPC_W(OPC_W)) u_size (
    .map(map_q), .opc(opc_q), .rex_w(rexw_q), .p66(p66_q), .p67(p67_q),
    .def_op_log(dop_q), .alt_op_log(aop_q), .def_ad_log(dad_q),
    .alt_ad_log(aad_q), .imm_ty(ent[TY_W-1:0]),
    .op_log(op_log), .ad_log(ad_log), .imm_n(look_imm)
  );

  xlw_modrm_dec #(.MAP_W(MAP_W), .OPC_W(OPC_W)) u_mrm (
    .mrm(in_byte), .ad16(addr_size == 4'd2), .map(map_q), .opc(opc_q),
    .op_bytes(op_size), .imm_in(imm_size),
    .disp_n(dec_disp), .want_sib(dec_sib), .imm_out(dec_imm)
  );

  assign in_ready = (st == ST_MODRM) || (st == ST_SIB) ||
                    (st == ST_DISP) || (st == ST_IMM);
  assign take     = in_ready && in_valid;
  assign disp_acc = disp | ({{(VAL_W-8){1'b0}}, in_byte} << {cnt[2:0], 3'b000});
  assign imm_acc  = imm  | ({{(VAL_W-8){1'b0}}, in_byte} << {cnt[2:0], 3'b000});

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      cnt       <= '0;
      map_q     <= '0;
      opc_q     <= '0;
      rexw_q    <= 1'b0;
      p66_q     <= 1'b0;
      p67_q     <= 1'b0;
      dop_q     <= 2'd2;
      aop_q     <= 2'd1;
      dad_q     <= 2'd2;
      aad_q     <= 2'd1;
      op_size   <= '0;
      addr_size <= '0;
      modrm     <= '0;
      sib       <= '0;
      disp      <= '0;
      disp_size <= '0;
      imm       <= '0;
      imm_size  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          map_q <= op_map;     opc_q <= opcode;
          rexw_q <= rex_w;     p66_q <= pfx_opsz;  p67_q <= pfx_adsz;
          dop_q <= def_op_log; aop_q <= alt_op_log;
          dad_q <= def_ad_log; aad_q <= alt_ad_log;
          modrm <= '0; sib <= '0; disp <= '0; imm <= '0;
          disp_size <= '0; imm_size <= '0; cnt <= '0;
          st <= ST_LOOK;
        end
        ST_LOOK: begin
          op_size   <= 4'd1 << op_log;
          addr_size <= 4'd1 << ad_log;
          imm_size  <= look_imm;
          if (ent[DW-1])            st <= ST_MODRM;
          else if (look_imm != '0)  st <= ST_IMM;
          else begin done <= 1'b1;  st <= ST_IDLE; end
        end
        ST_MODRM: if (take) begin
          modrm     <= in_byte;
          disp_size <= dec_disp;
          imm_size  <= dec_imm;
          if (dec_sib)              st <= ST_SIB;
          else if (dec_disp != '0)  st <= ST_DISP;
          else if (dec_imm != '0)   st <= ST_IMM;
          else begin done <= 1'b1;  st <= ST_IDLE; end
        end
        ST_SIB: if (take) begin
          sib <= in_byte;
          if (modrm[7:6] == 2'd0 && in_byte[2:0] == 3'd5) begin
            disp_size <= 3'd4;      st <= ST_DISP;
          end else if (disp_size != '0) st <= ST_DISP;
          else if (imm_size != '0)  st <= ST_IMM;
          else begin done <= 1'b1;  st <= ST_IDLE; end
        end
        ST_DISP: if (take) begin
          if (cnt + 4'd1 == {1'b0, disp_size}) begin
            disp <= widen(disp_acc, {1'b0, disp_size}, 1'b1);
            cnt  <= '0;
            if (imm_size != '0)     st <= ST_IMM;
            else begin done <= 1'b1; st <= ST_IDLE; end
          end else begin
            disp <= disp_acc;
            cnt  <= cnt + 4'd1;
          end
        end
        ST_IMM: if (take) begin
          if (cnt + 4'd1 == imm_size) begin
            imm  <= widen(imm_acc, imm_size, 1'b0);
            cnt  <= '0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            imm <= imm_acc;
            cnt <= cnt + 4'd1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlw_checks.sv
module xlw_checks #(
  parameter int VAL_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic             in_ready,
  input logic [3:0]       op_size,
  input logic [3:0]       addr_size,
  input logic [VAL_W-1:0] disp,
  input logic [2:0]       disp_size,
  input logic [VAL_W-1:0] imm,
  input logic [3:0]       imm_size
);
  a_r8_no_ready_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_op_size_legal: assert property (@(posedge clk) disable iff (rst)
    done |-> (op_size == 4'd2 || op_size == 4'd4 || op_size == 4'd8));
  a_r2_addr_size_legal: assert property (@(posedge clk) disable iff (rst)
    done |-> (addr_size == 4'd2 || addr_size == 4'd4 || addr_size == 4'd8));
  a_r4_no_wide_disp16: assert property (@(posedge clk) disable iff (rst)
    (done && addr_size == 4'd2) |-> (disp_size != 3'd4));
  a_r5_no_word_disp32: assert property (@(posedge clk) disable iff (rst)
    (done && addr_size != 4'd2) |-> (disp_size != 3'd2));
  a_r9_disp_byte_sext: assert property (@(posedge clk) disable iff (rst)
    (done && disp_size == 3'd1) |-> (disp[VAL_W-1:8] == {(VAL_W-8){disp[7]}}));
  a_r9_no_disp_zero: assert property (@(posedge clk) disable iff (rst)
    (done && disp_size == 3'd0) |-> (disp == '0));
  a_r10_imm_dword_sext: assert property (@(posedge clk) disable iff (rst)
    (done && imm_size == 4'd4) |-> (imm[VAL_W-1:32] == {(VAL_W-32){imm[31]}}));
  a_r10_imm_word_zext: assert property (@(posedge clk) disable iff (rst)
    (done && imm_size == 4'd2) |-> (imm[VAL_W-1:16] == '0));
endmodule

bind xlen_operand_walker xlw_checks #(.VAL_W(VAL_W)) u_checks (
  .clk(clk), .rst(rst), .done(done), .in_ready(in_ready),
  .op_size(op_size), .addr_size(addr_size), .disp(disp),
  .disp_size(disp_size), .imm(imm), .imm_size(imm_size)
);

// File: tb/xlen_operand_walker_test.sv
module xlen_operand_walker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic cfg_we = 0, cfg_modrm = 0, start = 0, rex_w = 0, pfx_opsz = 0, pfx_adsz = 0;
  logic [1:0] cfg_map = 0, op_map = 0;
  logic [7:0] cfg_opc = 0, opcode = 0, in_byte = 0;
  logic [2:0] cfg_imm_ty = 0;
  logic [1:0] def_op_log = 2, alt_op_log = 1, def_ad_log = 2, alt_ad_log = 1;
  logic in_valid = 0;
  logic in_ready, done;
  logic [3:0] op_size, addr_size, imm_size;
  logic [7:0] modrm, sib;
  logic [63:0] disp, imm;
  logic [2:0] disp_size;

  xlen_operand_walker uut (.*);

  typedef struct {
    logic [3:0] ops, ads, isz;
    logic [7:0] mrm, sb;
    logic [63:0] dsp, im;
    logic [2:0] dsz;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int tests = 0, fails = 0, cycles = 0;
  logic tb_mr [0:1023];
  logic [2:0] tb_ty [0:1023];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // monitor: compares every completion with the scoreboard head
  always @(negedge clk) begin
    if (!rst && done) begin
      exp_t e;
      tests = tests + 1;
      if (sb_q.size() == 0) begin
        fails = fails + 1;
        $display("FAIL R8 unexpected done: actual done=1 expected no completion");
      end else begin
        e = sb_q.pop_front();
        if (op_size !== e.ops || addr_size !== e.ads || modrm !== e.mrm ||
            sib !== e.sb || disp !== e.dsp || disp_size !== e.dsz ||
            imm !== e.im || imm_size !== e.isz) begin
          fails = fails + 1;
          $display("FAIL %s: actual op=%0d ad=%0d mrm=%h sib=%h disp=%h/%0d imm=%h/%0d expected op=%0d ad=%0d mrm=%h sib=%h disp=%h/%0d imm=%h/%0d",
            e.tag, op_size, addr_size, modrm, sib, disp, disp_size, imm, imm_size,
            e.ops, e.ads, e.mrm, e.sb, e.dsp, e.dsz, e.im, e.isz);
        end
      end
    end
  end

  function automatic logic [63:0] ext(logic [63:0] v, int n, bit s16);
    if (n == 1) return {{56{v[7]}}, v[7:0]};
    if (n == 2) return s16 ? {{48{v[15]}}, v[15:0]} : {48'd0, v[15:0]};
    if (n == 4) return {{32{v[31]}}, v[31:0]};
    if (n == 8) return v;
    return 64'd0;
  endfunction

  function automatic int cls(logic [2:0] ty, int bytes);
    case (ty)
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return (bytes > 4) ? 4 : bytes;
      3'd4: return bytes;
      default: return 0;
    endcase
  endfunction

  task automatic tbl(input logic [1:0] m, input logic [7:0] o, input logic mr,
                     input logic [2:0] ty);
    @(negedge clk);
    cfg_we = 1; cfg_map = m; cfg_opc = o; cfg_modrm = mr; cfg_imm_ty = ty;
    tb_mr[{m, o}] = mr; tb_ty[{m, o}] = ty;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // driver: models the expected result, pushes it, then streams bytes
  task automatic run(input string tag, input logic [1:0] m, input logic [7:0] o,
                     input logic rw, input logic p66, input logic p67,
                     input logic [1:0] dop, input logic [1:0] aop,
                     input logic [1:0] dad, input logic [1:0] aad,
                     input logic [7:0] mb, input logic [7:0] sbyte,
                     input logic [63:0] draw, input logic [63:0] iraw);
    exp_t e;
    logic [7:0] bytes[$];
    int opb, adb, isz, dsz, w;
    opb = rw ? 8 : (1 << (p66 ? aop : dop));
    adb = 1 << (p67 ? aad : dad);
    isz = cls(tb_ty[{m, o}], (m == 0 && o >= 8'hA0 && o <= 8'hA3) ? adb : opb);
    dsz = 0;
    e.mrm = 0; e.sb = 0;
    if (tb_mr[{m, o}]) begin
      bytes.push_back(mb); e.mrm = mb;
      if (adb == 2)
        dsz = ((mb[7:6] == 0 && mb[2:0] == 6) || mb[7:6] == 2) ? 2 : (mb[7:6] == 1) ? 1 : 0;
      else
        dsz = ((mb[7:6] == 0 && mb[2:0] == 5) || mb[7:6] == 2) ? 4 : (mb[7:6] == 1) ? 1 : 0;
      if (m == 0 && mb[5:4] == 2'b00) begin
        if (o == 8'hF6) isz = 1;
        if (o == 8'hF7) isz = (opb > 4) ? 4 : opb;
      end
      if (mb[2:0] == 4 && mb[7:6] != 3 && adb != 2) begin
        bytes.push_back(sbyte); e.sb = sbyte;
        if (mb[7:6] == 0 && sbyte[2:0] == 5) dsz = 4;
      end
    end
    for (int i = 0; i < dsz; i++) bytes.push_back(draw[8*i +: 8]);
    for (int i = 0; i < isz; i++) bytes.push_back(iraw[8*i +: 8]);
    e.ops = 4'(opb); e.ads = 4'(adb); e.dsz = 3'(dsz); e.isz = 4'(isz);
    e.dsp = ext(draw, dsz, 1'b1); e.im = ext(iraw, isz, 1'b0); e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    start = 1; op_map = m; opcode = o; rex_w = rw; pfx_opsz = p66; pfx_adsz = p67;
    def_op_log = dop; alt_op_log = aop; def_ad_log = dad; alt_ad_log = aad;
    @(negedge clk);
    start = 0;
    foreach (bytes[k]) begin
      w = 0;
      while (!in_ready && w < 10) begin @(negedge clk); w++; end
      in_valid = 1; in_byte = bytes[k];
      @(negedge clk);
      in_valid = 0;
    end
    w = 0;
    while (!done && w < 10) begin @(negedge clk); w++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL %s R8 done missing: actual done=0 expected done=1", tag);
      void'(sb_q.pop_front());
    end
    @(negedge clk);
    tests++;
    if (in_ready !== 1'b0) begin
      fails++;
      $display("FAIL %s R8 ready after done: actual %b expected 0", tag, in_ready);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tests++;
    if (done !== 0 || in_ready !== 0 || disp !== 0 || imm !== 0) begin
      fails++;
      $display("FAIL R8 reset: actual done=%b ready=%b disp=%h imm=%h expected all 0",
               done, in_ready, disp, imm);
    end
    // R3 table contents
    tbl(0, 8'h90, 0, 3'd0); tbl(0, 8'h05, 0, 3'd3); tbl(0, 8'hB8, 0, 3'd4);
    tbl(0, 8'hA1, 0, 3'd4); tbl(0, 8'h01, 1, 3'd0); tbl(0, 8'h81, 1, 3'd3);
    tbl(0, 8'hF7, 1, 3'd0); tbl(0, 8'hF6, 1, 3'd0); tbl(0, 8'h6A, 0, 3'd1);
    tbl(0, 8'hC2, 0, 3'd2); tbl(2, 8'h00, 1, 3'd0); tbl(3, 8'h0F, 1, 3'd1);

    run("R8 no fields", 0, 8'h90, 0,0,0, 2,1,2,1, 0,0, 0,0);
    run("R1 R10 dword imm sext", 0, 8'h05, 0,0,0, 2,1,2,1, 0,0, 0, 64'h80000001);
    run("R1 R10 word imm via 66", 0, 8'h05, 0,1,0, 2,1,2,1, 0,0, 0, 64'h8001);
    run("R1 rex.w full imm", 0, 8'hB8, 1,1,0, 2,1,3,2, 0,0, 0, 64'hF123456789ABCDEF);
    run("R3 moffs addr sized 8", 0, 8'hA1, 0,0,0, 2,1,3,2, 0,0, 0, 64'h1122334455667788);
    run("R2 R3 moffs addr via 67", 0, 8'hA1, 0,0,1, 1,2,3,2, 0,0, 0, 64'h99AABBCC);
    run("R5 disp32 rm5", 0, 8'h01, 0,0,0, 2,1,2,1, 8'h05,0, 64'h87654321, 0);
    run("R4 R9 disp16 rm6 sext", 0, 8'h01, 0,0,0, 1,2,1,2, 8'h06,0, 64'h8000, 0);
    run("R4 R6 no sib in 16-bit", 0, 8'h01, 0,0,1, 2,1,2,1, 8'h44,8'hAA, 64'h7F, 0);
    run("R6 sib base5 forces disp4", 0, 8'h01, 0,0,0, 2,1,3,2, 8'h04,8'h25, 64'h00001234, 0);
    run("R6 sib without disp", 0, 8'h01, 0,0,0, 2,1,3,2, 8'h0C,8'h20, 0, 0);
    run("R8 sib disp imm order", 0, 8'h81, 0,0,0, 2,1,2,1, 8'h84,8'h18, 64'hFFFFFF80, 64'h7ABBCCDD);
    run("R7 F7 test imm capped", 0, 8'hF7, 1,0,0, 2,1,3,2, 8'hC0,0, 0, 64'hFFFFFFFE);
    run("R7 F7 reg2 no imm", 0, 8'hF7, 0,0,0, 2,1,2,1, 8'hD0,0, 0, 0);
    run("R7 F6 reg1 byte imm", 0, 8'hF6, 0,0,0, 2,1,2,1, 8'hC8,0, 0, 64'h85);
    run("R9 map 0F38 disp8 sext", 2, 8'h00, 0,0,0, 2,1,3,2, 8'h41,0, 64'h80, 0);
    run("R3 map 0F3A byte imm", 3, 8'h0F, 0,0,0, 2,1,3,2, 8'hC1,0, 0, 64'h7F);
    run("R10 byte imm sext", 0, 8'h6A, 0,0,0, 2,1,2,1, 0,0, 0, 64'hFF);
    run("R10 word class unchanged", 0, 8'hC2, 1,0,0, 2,1,3,2, 0,0, 0, 64'hFFFE);

    repeat (3) @(negedge clk);
    tests++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R8 leftover items: actual %0d expected 0", sb_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule